// File: doc/BRIEF.md
# Tagged Command and Status Queue Host Bridge

This block sits between a host register port and a task-processing engine. The host submits each task by writing two 32-bit words to one command port. The first word is the tagged command and the second is the task descriptor address. The bridge pairs the two words and queues them as one entry. The engine takes entries from a valid/ready command stream and hands results back on a valid/ready status stream. The host pops those results through a status port. Each result word carries the task and client tags of the command it answers.

A status interrupt tells the host that results are waiting. A separate error interrupt reports that one of three memory-interface error words has been captured. When the command queue is already full, the bridge drops the newest task and writes a task-list-full result into the status queue itself. The block also holds a clock-enable field for three processing sub-units and a fixed version identifier.

Stream rules: a command entry is offered while the command queue holds data. It stays stable until `cmd_ready` is seen high on a clock edge with `cmd_valid` high. The engine may hold `sts_valid` for as long as it likes. A status word is taken only on an edge where both `sts_valid` and `sts_ready` are high. `sts_ready` falls when the status queue is full, and for one cycle whenever the bridge inserts its own task-list-full result.

Top module: `tqb_host_bridge`

## Requirements
- R1: After reset the following hold: `irq_status`, `irq_error` and `cmd_valid` are 0, `clk_gate_en` is 0, `sts_ready` is 1, and the fill level reads 0.
- R2: The first write to the command port (offset 0x114) is held in a staging register, and no entry is offered on the command stream. The next write to the same port completes the entry: `cmd_word` is the first word and `cmd_desc` is the second. Entries leave in the order they were completed, and each one stays stable while `cmd_ready` is low.
- R3: Any write to offset 0x100 throws away a staged first word. After such a write, offset 0x104 reads 1 once, and reads 0 from then on until the next write to 0x100.
- R4: A status word is stored unchanged when `sts_valid` and `sts_ready` are both high on an edge. `sts_ready` is 0 while the status queue holds STS_DEPTH entries, and an offered word is then not taken.
- R5: A read of offset 0x118 pops the oldest status entry. `reg_rdata` holds that entry from the clock edge of the read onward. Entries use task_id in bits 31:16, client_id in bits 15:8 and the code in bits 7:0.
- R6: A read of offset 0x118 while the status queue is empty returns 0 and leaves the fill level unchanged.
- R7: Offset 0x11C returns the number of queued status entries in its low 4 bits.
- R8: Every push into the status queue makes `irq_status` pending. Writing bit 0 = 1 to offset 0x120 clears the pending state, and `irq_status` is also low whenever the status queue is empty. When a push and an acknowledge fall in the same cycle, the push wins.
- R9: If the second command word arrives while the command queue is full, the task is dropped. The word {task_id, client_id, 0xF0} taken from its first word is pushed into the status queue instead, ahead of any engine status word offered in that cycle. The report is lost only if the status queue is also full.
- R10: A pulse on `err_strobe[i]` loads `err_word` into error register i, but only if that register is 0, so the first error is kept. The registers read at 0x128 (i=0), 0x12C (i=1) and 0x130 (i=2). `irq_error` is high while any of them is nonzero. Writing bit 0 = 1 to offset 0x124 clears all three.
- R11: Offset 0x148 holds a read/write field in bits 2:0 that drives `clk_gate_en`. Offset 0x14C returns VERSION_ID in its low 16 bits and 0 above them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, registered on the edge of the read |
| cmd_valid | output | 1 | Command entry offered |
| cmd_ready | input | 1 | Engine takes the command entry |
| cmd_word | output | 32 | Tagged command word of the entry |
| cmd_desc | output | 32 | Descriptor address of the entry |
| sts_valid | input | 1 | Engine offers a status word |
| sts_ready | output | 1 | Bridge can take a status word |
| sts_word | input | 32 | Status word from the engine |
| err_strobe | input | 3 | Per-register error capture pulse |
| err_word | input | 32 | Error word to capture |
| irq_status | output | 1 | Status interrupt |
| irq_error | output | 1 | Error interrupt |
| clk_gate_en | output | 3 | Sub-unit clock enables |

## Verification
Two pairs of functions can land in the same cycle, and each is provoked on purpose. The first pair is the interrupt acknowledge and an engine status push. The bench drives the acknowledge write and `sts_valid` on the same edge while an entry is already pending. It then requires `irq_status` to stay high and the fill level to reach two. The second pair is the bridge's own task-list-full report and an engine status word. The bench completes a command into a full queue while `sts_valid` is held high. It expects `sts_ready` low in that cycle and high in the next, and it expects the two words to pop with the 0xF0 report first.

// File: rtl/tqb_pkg.sv
package tqb_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int N_ERR  = 3;
  localparam int N_GATE = 3;

  localparam logic [ADDR_W-1:0] OFS_RST      = 12'h100;
  localparam logic [ADDR_W-1:0] OFS_RST_ACK  = 12'h104;
  localparam logic [ADDR_W-1:0] OFS_CMD      = 12'h114;
  localparam logic [ADDR_W-1:0] OFS_STS      = 12'h118;
  localparam logic [ADDR_W-1:0] OFS_FILL     = 12'h11C;
  localparam logic [ADDR_W-1:0] OFS_ACK      = 12'h120;
  localparam logic [ADDR_W-1:0] OFS_ERR_ACK  = 12'h124;
  localparam logic [ADDR_W-1:0] OFS_ERR_LOC  = 12'h128;
  localparam logic [ADDR_W-1:0] OFS_ERR_EXT  = 12'h12C;
  localparam logic [ADDR_W-1:0] OFS_ERR_SEC  = 12'h130;
  localparam logic [ADDR_W-1:0] OFS_GATE     = 12'h148;
  localparam logic [ADDR_W-1:0] OFS_VER      = 12'h14C;

  typedef enum logic [7:0] {
    CODE_OK         = 8'h00,
    CODE_OVERSIZE   = 8'h02,
    CODE_SKIPPED    = 8'h04,
    CODE_SLICE_SIZE = 8'h05,
    CODE_SLICE_MAX  = 8'h07,
    CODE_SLICE_RDY  = 8'h08,
    CODE_LIST_FULL  = 8'hF0,
    CODE_BAD_CMD    = 8'hF1,
    CODE_BAD_FMT    = 8'hF4
  } tqb_code_e;
endpackage

// File: rtl/tqb_fifo.sv
module tqb_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= step(wp);
      if (do_pop)  rp <= step(rp);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end
endmodule

// File: rtl/tqb_cmd_stage.sv
module tqb_cmd_stage
  import tqb_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_wr,
  input  logic                clr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                q_full,
  input  logic                sts_full,
  output logic                staged,
  output logic                push,
  output logic [2*DATA_W-1:0] entry,
  output logic                inject,
  output logic [DATA_W-1:0]   inject_word
);
  logic [DATA_W-1:0] first;
  logic              second;

  assign second      = cmd_wr && staged && !clr;
  assign push        = second && !q_full;
  assign inject      = second && q_full && !sts_full;
  assign entry       = {first, wdata};
  assign inject_word = {first[DATA_W-1:8], CODE_LIST_FULL};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged <= 1'b0;
      first  <= '0;
    end else if (clr) begin
      staged <= 1'b0;
    end else if (cmd_wr) begin
      if (!staged) begin
        first  <= wdata;
        staged <= 1'b1;
      end else begin
        staged <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tqb_event_ctrl.sv
module tqb_event_ctrl
  import tqb_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sts_push,
  input  logic                         sts_empty,
  input  logic                         ack_wr,
  input  logic                         err_ack_wr,
  input  logic [N_ERR-1:0]             err_strobe,
  input  logic [DATA_W-1:0]            err_word,
  output logic                         irq_status,
  output logic                         irq_error,
  output logic [N_ERR-1:0][DATA_W-1:0] err_regs
);
  logic pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend <= 1'b0;
    else if (sts_push) pend <= 1'b1;
    else if (ack_wr)   pend <= 1'b0;
  end

  assign irq_status = pend && !sts_empty;

  for (genvar i = 0; i < N_ERR; i++) begin : g_err
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        err_regs[i] <= '0;
      else if (err_strobe[i] && (err_regs[i] == '0 || err_ack_wr))
        err_regs[i] <= err_word;
      else if (err_ack_wr)
        err_regs[i] <= '0;
    end
  end

  assign irq_error = |err_regs;
endmodule

// File: rtl/tqb_host_bridge.sv
module tqb_host_bridge
  import tqb_pkg::*;
#(
  parameter int          CMD_DEPTH  = 4,
  parameter int          STS_DEPTH  = 8,
  parameter logic [15:0] VERSION_ID = 16'h0A17,
  localparam int         CCW        = $clog2(CMD_DEPTH + 1),
  localparam int         SCW        = $clog2(STS_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [DATA_W-1:0] cmd_word,
  output logic [DATA_W-1:0] cmd_desc,
  input  logic              sts_valid,
  output logic              sts_ready,
  input  logic [DATA_W-1:0] sts_word,
  input  logic [N_ERR-1:0]  err_strobe,
  input  logic [DATA_W-1:0] err_word,
  output logic              irq_status,
  output logic              irq_error,
  output logic [N_GATE-1:0] clk_gate_en
);
  // register decode
  logic rst_wr, cmd_wr, ack_wr, err_ack_wr, sts_pop, rst_ack_rd;
  assign rst_wr     = reg_wr && (reg_addr == OFS_RST);
  assign cmd_wr     = reg_wr && (reg_addr == OFS_CMD);
  assign ack_wr     = reg_wr && (reg_addr == OFS_ACK) && reg_wdata[0];
  assign err_ack_wr = reg_wr && (reg_addr == OFS_ERR_ACK) && reg_wdata[0];
  assign sts_pop    = reg_rd && (reg_addr == OFS_STS);
  assign rst_ack_rd = reg_rd && (reg_addr == OFS_RST_ACK);

  // command path
  logic                staged, cmd_push, inject, cmd_full, cmd_empty;
  logic [2*DATA_W-1:0] cmd_entry, cmd_head;
  logic [DATA_W-1:0]   inject_word;
  logic [CCW-1:0]      cmd_count;
  logic                sts_full;

  tqb_cmd_stage u_stage (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .clr(rst_wr), .wdata(reg_wdata),
    .q_full(cmd_full), .sts_full(sts_full), .staged(staged), .push(cmd_push),
    .entry(cmd_entry), .inject(inject), .inject_word(inject_word)
  );

  tqb_fifo #(.W(2*DATA_W), .DEPTH(CMD_DEPTH)) u_cmdq (
    .clk(clk), .rst_n(rst_n), .push(cmd_push), .wdata(cmd_entry),
    .pop(cmd_valid && cmd_ready), .rdata(cmd_head), .full(cmd_full),
    .empty(cmd_empty), .count(cmd_count)
  );

  assign cmd_valid = !cmd_empty;
  assign cmd_word  = cmd_head[2*DATA_W-1:DATA_W];
  assign cmd_desc  = cmd_head[DATA_W-1:0];

  // status path: the bridge's own list-full report has priority
  logic              sts_push, sts_empty;
  logic [DATA_W-1:0] sts_wdata, sts_head;
  logic [SCW-1:0]    sts_count;

  assign sts_ready = !sts_full && !inject;
  assign sts_push  = inject || (sts_valid && sts_ready);
  assign sts_wdata = inject ? inject_word : sts_word;

  tqb_fifo #(.W(DATA_W), .DEPTH(STS_DEPTH)) u_stsq (
    .clk(clk), .rst_n(rst_n), .push(sts_push), .wdata(sts_wdata),
    .pop(sts_pop), .rdata(sts_head), .full(sts_full),
    .empty(sts_empty), .count(sts_count)
  );

  // interrupts and error capture
  logic [N_ERR-1:0][DATA_W-1:0] err_regs;

  tqb_event_ctrl u_evt (
    .clk(clk), .rst_n(rst_n), .sts_push(sts_push), .sts_empty(sts_empty),
    .ack_wr(ack_wr), .err_ack_wr(err_ack_wr), .err_strobe(err_strobe),
    .err_word(err_word), .irq_status(irq_status), .irq_error(irq_error),
    .err_regs(err_regs)
  );

  // control registers
  logic rst_flag;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_gate_en <= '0;
      rst_flag    <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == OFS_GATE) clk_gate_en <= reg_wdata[N_GATE-1:0];
      if (rst_wr)          rst_flag <= 1'b1;
      else if (rst_ack_rd) rst_flag <= 1'b0;
    end
  end

  // read mux, registered
  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    unique case (reg_addr)
      OFS_RST_ACK: rd_mux = DATA_W'(rst_flag);
      OFS_STS:     rd_mux = sts_empty ? '0 : sts_head;
      OFS_FILL:    rd_mux = DATA_W'(sts_count);
      OFS_ERR_LOC: rd_mux = err_regs[0];
      OFS_ERR_EXT: rd_mux = err_regs[1];
      OFS_ERR_SEC: rd_mux = err_regs[2];
      OFS_GATE:    rd_mux = DATA_W'(clk_gate_en);
      OFS_VER:     rd_mux = DATA_W'(VERSION_ID);
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/tqb_host_bridge_chk.sv
module tqb_host_bridge_chk
  import tqb_pkg::*;
#(
  parameter int  CMD_DEPTH = 4,
  parameter int  STS_DEPTH = 8,
  localparam int CCW       = $clog2(CMD_DEPTH + 1),
  localparam int SCW       = $clog2(STS_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [DATA_W-1:0] cmd_word,
  input logic [DATA_W-1:0] cmd_desc,
  input logic              sts_ready,
  input logic              irq_status,
  input logic              irq_error,
  input logic [N_ERR-1:0]  err_strobe,
  input logic [CCW-1:0]    cmd_count,
  input logic [SCW-1:0]    sts_count,
  input logic              staged,
  input logic              sts_push
);
  logic cmd_take;
  assign cmd_take = cmd_valid && cmd_ready;

  assert_cmd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_word) && $stable(cmd_desc)));

  assert_first_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_CMD && !staged && !cmd_take) |=> $stable(cmd_count));

  assert_backpressure_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_count == SCW'(STS_DEPTH)) |-> !sts_ready);

  assert_fill_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sts_count <= SCW'(STS_DEPTH));

  assert_irq_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_ACK && reg_wdata[0] && !sts_push) |=> !irq_status);

  assert_irq_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_status |-> (sts_count != '0));

  assert_list_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_CMD && staged && cmd_count == CCW'(CMD_DEPTH) && !cmd_take)
      |=> (cmd_count == CCW'(CMD_DEPTH)));

  assert_err_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_error) |-> $past(|err_strobe));
endmodule

bind tqb_host_bridge tqb_host_bridge_chk #(.CMD_DEPTH(CMD_DEPTH), .STS_DEPTH(STS_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_word(cmd_word), .cmd_desc(cmd_desc),
  .sts_ready(sts_ready), .irq_status(irq_status), .irq_error(irq_error),
  .err_strobe(err_strobe), .cmd_count(cmd_count), .sts_count(sts_count),
  .staged(staged), .sts_push(sts_push)
);

// File: tb/sim_tqb_host_bridge.sv
module sim_tqb_host_bridge;
  import tqb_pkg::*;

  localparam int          CLK_P = 10;
  localparam int          CMD_D = 4;
  localparam int          STS_D = 8;
  localparam logic [15:0] VER   = 16'h0A17;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0, reg_rd = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              cmd_valid, cmd_ready = 1'b0;
  logic [DATA_W-1:0] cmd_word, cmd_desc;
  logic              sts_valid = 1'b0, sts_ready;
  logic [DATA_W-1:0] sts_word = '0;
  logic [N_ERR-1:0]  err_strobe = '0;
  logic [DATA_W-1:0] err_word = '0;
  logic              irq_status, irq_error;
  logic [N_GATE-1:0] clk_gate_en;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  tqb_host_bridge #(.CMD_DEPTH(CMD_D), .STS_DEPTH(STS_D), .VERSION_ID(VER)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_word(cmd_word), .cmd_desc(cmd_desc),
    .sts_valid(sts_valid), .sts_ready(sts_ready), .sts_word(sts_word),
    .err_strobe(err_strobe), .err_word(err_word), .irq_status(irq_status),
    .irq_error(irq_error), .clk_gate_en(clk_gate_en)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic rd_check(input string tag, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  // engine stub: offer one status word until taken
  task automatic engine_status(input logic [31:0] w);
    @(negedge clk); sts_valid = 1'b1; sts_word = w; #1;
    while (!sts_ready) @(negedge clk);
    @(negedge clk); sts_valid = 1'b0;
  endtask

  // engine stub: take one command entry and check it
  task automatic engine_take(input string tag, input logic [31:0] ew, input logic [31:0] ed);
    @(negedge clk);
    check({tag, " valid"}, 32'(cmd_valid), 32'd1);
    check({tag, " word"}, cmd_word, ew);
    check({tag, " desc"}, cmd_desc, ed);
    cmd_ready = 1'b1;
    @(negedge clk); cmd_ready = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 irq_status", 32'(irq_status), 0);
    check("R1 irq_error", 32'(irq_error), 0);
    check("R1 cmd_valid", 32'(cmd_valid), 0);
    check("R1 gate", 32'(clk_gate_en), 0);
    check("R1 sts_ready", 32'(sts_ready), 1);
    rd_check("R1 fill", OFS_FILL, 0);
  endtask

  task automatic t_cmd_pair();
    wr(OFS_CMD, 32'h0012_0301);
    check("R2 nothing after first word", 32'(cmd_valid), 0);
    wr(OFS_CMD, 32'h8000_1000);
    wr(OFS_CMD, 32'h0013_0401);
    wr(OFS_CMD, 32'h8000_2000);
    engine_take("R2 first entry", 32'h0012_0301, 32'h8000_1000);
    engine_take("R2 second entry", 32'h0013_0401, 32'h8000_2000);
    check("R2 drained", 32'(cmd_valid), 0);
  endtask

  task automatic t_soft_reset();
    wr(OFS_CMD, 32'h0099_0101);
    wr(OFS_RST, 32'h1);
    rd_check("R3 reset ack first read", OFS_RST_ACK, 1);
    rd_check("R3 reset ack second read", OFS_RST_ACK, 0);
    wr(OFS_CMD, 32'h0021_0201);
    check("R3 staged word dropped", 32'(cmd_valid), 0);
    wr(OFS_CMD, 32'h8000_3000);
    engine_take("R3 entry after reset", 32'h0021_0201, 32'h8000_3000);
  endtask

  task automatic t_status_pop();
    engine_status(32'h0012_0300);
    check("R8 irq after push", 32'(irq_status), 1);
    rd_check("R7 fill one", OFS_FILL, 1);
    rd_check("R5 pop entry", OFS_STS, 32'h0012_0300);
    check("R8 irq low when empty", 32'(irq_status), 0);
    rd_check("R7 fill zero", OFS_FILL, 0);
  endtask

  task automatic t_empty_pop();
    rd_check("R6 empty pop", OFS_STS, 0);
    rd_check("R6 fill unchanged", OFS_FILL, 0);
  endtask

  task automatic t_ack();
    engine_status(32'h0001_0100);
    engine_status(32'h0002_0108);
    check("R8 irq pending", 32'(irq_status), 1);
    wr(OFS_ACK, 32'h1);
    check("R8 irq cleared by ack", 32'(irq_status), 0);
    rd_check("R8 entries kept after ack", OFS_FILL, 2);
    engine_status(32'h0003_0104);
    check("R8 irq re-raised", 32'(irq_status), 1);
    wr(OFS_ACK, 32'h1);
    rd_check("R5 order 1", OFS_STS, 32'h0001_0100);
    rd_check("R5 order 2", OFS_STS, 32'h0002_0108);
    rd_check("R5 order 3", OFS_STS, 32'h0003_0104);
  endtask

  task automatic t_ack_push_collide();
    engine_status(32'h0004_0100);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = OFS_ACK; reg_wdata = 32'h1;
    sts_valid = 1'b1; sts_word = 32'h0005_0102;
    @(negedge clk);
    reg_wr = 1'b0; sts_valid = 1'b0;
    check("R8 push wins over ack", 32'(irq_status), 1);
    rd_check("R8 fill after collision", OFS_FILL, 2);
    rd_check("R5 drain a", OFS_STS, 32'h0004_0100);
    rd_check("R5 drain b", OFS_STS, 32'h0005_0102);
  endtask

  task automatic fill_cmdq(input logic [7:0] base);
    for (int i = 0; i < CMD_D; i++) begin
      wr(OFS_CMD, {8'h00, base + 8'(i), 16'h0301});
      wr(OFS_CMD, 32'h9000_0000 + 32'(i));
    end
  endtask

  task automatic drain_cmdq(input string tag, input logic [7:0] base);
    for (int i = 0; i < CMD_D; i++)
      engine_take(tag, {8'h00, base + 8'(i), 16'h0301}, 32'h9000_0000 + 32'(i));
    check({tag, " empty"}, 32'(cmd_valid), 0);
  endtask

  task automatic t_list_full();
    fill_cmdq(8'h40);
    wr(OFS_CMD, 32'h00AB_0502);
    wr(OFS_CMD, 32'h9ABC_0000);
    rd_check("R9 report queued", OFS_FILL, 1);
    rd_check("R9 report word", OFS_STS, 32'h00AB_05F0);
    drain_cmdq("R9 queue untouched", 8'h40);
    wr(OFS_ACK, 32'h1);
  endtask

  task automatic t_inject_collide();
    fill_cmdq(8'h50);
    wr(OFS_CMD, 32'h00CD_0602);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = OFS_CMD; reg_wdata = 32'h9DEF_0000;
    sts_valid = 1'b1; sts_word = 32'h0077_0108;
    #1 check("R9 sts_ready low during report", 32'(sts_ready), 0);
    @(negedge clk);
    reg_wr = 1'b0;
    #1 check("R4 sts_ready back", 32'(sts_ready), 1);
    @(negedge clk);
    sts_valid = 1'b0;
    rd_check("R9 report first", OFS_STS, 32'h00CD_06F0);
    rd_check("R4 engine word second", OFS_STS, 32'h0077_0108);
    drain_cmdq("R9 collide queue", 8'h50);
    wr(OFS_ACK, 32'h1);
  endtask

  task automatic t_backpressure();
    for (int i = 0; i < STS_D; i++) engine_status(32'h0100_0000 + 32'(i));
    check("R4 ready low when full", 32'(sts_ready), 0);
    @(negedge clk); sts_valid = 1'b1; sts_word = 32'hBAD0_BAD0;
    repeat (3) @(negedge clk);
    sts_valid = 1'b0;
    rd_check("R7 fill full", OFS_FILL, STS_D);
    for (int i = 0; i < STS_D; i++)
      rd_check("R4 stored word", OFS_STS, 32'h0100_0000 + 32'(i));
    rd_check("R4 extra word not taken", OFS_FILL, 0);
  endtask

  task automatic t_errors();
    check("R10 idle", 32'(irq_error), 0);
    @(negedge clk); err_strobe = 3'b010; err_word = 32'hDEAD_0001;
    @(negedge clk); err_strobe = 3'b000;
    check("R10 irq_error raised", 32'(irq_error), 1);
    @(negedge clk); err_strobe = 3'b010; err_word = 32'h0000_0002;
    @(negedge clk); err_strobe = 3'b000;
    rd_check("R10 first error kept", OFS_ERR_EXT, 32'hDEAD_0001);
    rd_check("R10 other reg zero", OFS_ERR_LOC, 0);
    wr(OFS_ERR_ACK, 32'h1);
    check("R10 cleared", 32'(irq_error), 0);
    rd_check("R10 reg cleared", OFS_ERR_EXT, 0);
    @(negedge clk); err_strobe = 3'b101; err_word = 32'h0000_0005;
    @(negedge clk); err_strobe = 3'b000;
    rd_check("R10 local reg", OFS_ERR_LOC, 5);
    rd_check("R10 secondary reg", OFS_ERR_SEC, 5);
    wr(OFS_ERR_ACK, 32'h1);
  endtask

  task automatic t_gate_version();
    wr(OFS_GATE, 32'hFFFF_FFF5);
    check("R11 gate pins", 32'(clk_gate_en), 5);
    rd_check("R11 gate readback", OFS_GATE, 5);
    rd_check("R11 version", OFS_VER, {16'h0, VER});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_cmd_pair();
    t_soft_reset();
    t_status_pop();
    t_empty_pop();
    t_ack();
    t_ack_push_collide();
    t_list_full();
    t_inject_collide();
    t_backpressure();
    t_errors();
    t_gate_version();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule